// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Controller

This block gathers sixteen single-cycle event pulses into two 8-bit status registers. Each status register has an 8-bit enable register beside it. A status bit latches its event whether or not the bit is enabled. Only enabled bits pull the active-low request output low.

A host reads and writes the four registers through a simple port: address, write data, write strobe, read strobe and read data. Reading a status register with the read strobe clears the bits in it that are enabled. The bits that are not enabled keep their value, so a host can poll them at any time. The power-on-reset status bit is set when reset is released. It is the only bit enabled at reset, so the request line is active right after reset until the host reads status register 2.

Top module: `irq_gather`

## Requirements
- R1: After reset, status 1 reads 00h, status 2 reads 01h (power-on-reset bit set), enable 1 reads 00h, enable 2 reads 01h, and irq_n is low.
- R2: Address 03h returns status 1, 04h returns status 2, 05h returns enable 1 and 06h returns enable 2. A write to 05h or 06h stores the write data, which then reads back unchanged. Any other address reads 00h. reg_rdata follows reg_addr combinationally, with or without the read strobe.
- R3: A one on evt_a[k] sets bit k of status 1, and a one on evt_b[k] sets bit k of status 2, whatever the enable bits hold. Status 1 bits, from 7 down to 0: FIFO error, TX FIFO almost full, TX FIFO almost empty, RX FIFO almost full, external, packet sent, packet valid, CRC error. Status 2 bits, from 7 down to 0: sync word found, preamble valid, preamble invalid, RSSI, wake-up timer, low battery, chip ready, power-on reset.
- R4: irq_n is low exactly when (status 1 AND enable 1) OR (status 2 AND enable 2) is nonzero. A change to an enable register acts on the request line in the next cycle.
- R5: A strobed read of a status register clears every bit in it whose enable bit is set when the read happens.
- R6: A strobed read of a status register leaves its bits whose enable bit is clear unchanged.
- R7: The read data of a strobed status read is the status value before the clear takes effect.
- R8: An event that arrives in the same cycle as a clearing read of its register leaves its bit set afterwards.
- R9: A write to a status address or to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_a | input | 8 | Event pulses for status register 1 |
| evt_b | input | 8 | Event pulses for status register 2 |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of a status register clears its enabled bits |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench drives events while their enable bits are clear, then enables them. A design that masked the latch instead of the request would lose these events, and one that ignored enables would pull irq_n low too early. A strobed read with a mixed enable pattern checks that only enabled bits clear and that the read data shows the value before the clear. A design that cleared the whole register, or returned the cleared value, fails here. An event that lands in the same cycle as a clearing read must survive the read; a design that let the clear win would drop it. Writes to status and unmapped addresses must leave every register unchanged.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_A_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] STAT_B_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] EN_A_ADDR   = 'h05,
  parameter logic [ADDR_W-1:0] EN_B_ADDR   = 'h06,
  parameter logic [DATA_W-1:0] EN_A_RST    = 'h00,
  parameter logic [DATA_W-1:0] EN_B_RST    = 'h01,
  parameter logic [DATA_W-1:0] STAT_B_RST  = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_a,
  input  logic [DATA_W-1:0] evt_b,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);

  logic [DATA_W-1:0] stat_a, stat_b, en_a, en_b;

  wire rd_a = reg_rd && (reg_addr == STAT_A_ADDR);
  wire rd_b = reg_rd && (reg_addr == STAT_B_ADDR);
  wire wr_a = reg_wr && (reg_addr == EN_A_ADDR);
  wire wr_b = reg_wr && (reg_addr == EN_B_ADDR);

  wire [DATA_W-1:0] keep_a = rd_a ? ~en_a : '1;
  wire [DATA_W-1:0] keep_b = rd_b ? ~en_b : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_a <= '0;
      stat_b <= STAT_B_RST;
    end else begin
      stat_a <= (stat_a & keep_a) | evt_a;
      stat_b <= (stat_b & keep_b) | evt_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a <= EN_A_RST;
      en_b <= EN_B_RST;
    end else begin
      if (wr_a) en_a <= reg_wdata;
      if (wr_b) en_b <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      STAT_A_ADDR: reg_rdata = stat_a;
      STAT_B_ADDR: reg_rdata = stat_b;
      EN_A_ADDR:   reg_rdata = en_a;
      EN_B_ADDR:   reg_rdata = en_b;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq_n = ~|((stat_a & en_a) | (stat_b & en_b));

  // R3 / R8: every pulsed event is held in the following cycle, even across a clearing read
  a_r3_latch_a: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_a & $past(evt_a)) == $past(evt_a)));
  a_r3_latch_b: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_b & $past(evt_b)) == $past(evt_b)));

  // R5: enabled bits without a new event are gone after a strobed read
  a_r5_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a |=> ((stat_a & $past(en_a) & ~$past(evt_a)) == '0));
  a_r5_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b |=> ((stat_b & $past(en_b) & ~$past(evt_b)) == '0));

  // R6: disabled bits survive a strobed read
  a_r6_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a |=> (($past(stat_a) & ~$past(en_a) & ~stat_a) == '0));
  a_r6_keep_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b |=> (($past(stat_b) & ~$past(en_b) & ~stat_b) == '0));

  // R2: an enable write lands as written
  a_r2_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> (en_a == $past(reg_wdata)));

  // R9: with no read and no event, status holds; without an enable write, enables hold
  a_r9_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_a && evt_a == '0) |=> $stable(stat_a));
  a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_a && !wr_b) |=> ($stable(en_a) && $stable(en_b)));

endmodule

// File: tb/irq_gather_bench.sv
module irq_gather_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_a = '0, evt_b = '0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gather u_irq_gather (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] addr, output logic [7:0] data);
    @(negedge clk);
    reg_addr = addr;
    #1 data = reg_rdata;
  endtask

  task automatic rd(input logic [7:0] addr, input logic [7:0] ea, output logic [7:0] data);
    @(negedge clk);
    reg_addr = addr; reg_rd = 1'b1; evt_a = ea;
    #1 data = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; evt_a = '0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    reg_addr = addr; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    evt_a = a; evt_b = b;
    @(negedge clk);
    evt_a = '0; evt_b = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek(8'h03, d); check("R1 status1", d, 8'h00);
    peek(8'h04, d); check("R1 status2 por", d, 8'h01);
    peek(8'h05, d); check("R1 enable1", d, 8'h00);
    peek(8'h06, d); check("R1 enable2", d, 8'h01);
    check("R1 irq_n low", {7'd0, irq_n}, 8'h00);
  endtask

  task automatic t_por_clear;
    logic [7:0] d;
    rd(8'h04, 8'h00, d); check("R7 por read value", d, 8'h01);
    peek(8'h04, d);      check("R5 por cleared", d, 8'h00);
    check("R4 irq_n high after clear", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_masked_latch;
    logic [7:0] d;
    pulse(8'hA5, 8'h3C);
    peek(8'h03, d); check("R3 status1 latched while masked", d, 8'hA5);
    peek(8'h04, d); check("R3 status2 latched while masked", d, 8'h3C);
    check("R4 irq_n stays high when masked", {7'd0, irq_n}, 8'h01);
    rd(8'h03, 8'h00, d); check("R6 masked read value", d, 8'hA5);
    peek(8'h03, d); check("R6 masked bits survive read", d, 8'hA5);
  endtask

  task automatic t_enable_and_clear;
    logic [7:0] d;
    wr(8'h05, 8'h05);
    peek(8'h05, d); check("R2 enable1 readback", d, 8'h05);
    check("R4 irq_n low after enable", {7'd0, irq_n}, 8'h00);
    rd(8'h03, 8'h00, d); check("R7 pre-clear value", d, 8'hA5);
    peek(8'h03, d); check("R5 enabled bits cleared only", d, 8'hA0);
    check("R4 irq_n high after enabled clear", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    wr(8'h05, 8'hFF);
    check("R4 irq_n low with all enabled", {7'd0, irq_n}, 8'h00);
    rd(8'h03, 8'h02, d); check("R7 value at colliding read", d, 8'hA0);
    peek(8'h03, d); check("R8 event kept at clearing read", d, 8'h02);
    check("R4 irq_n low for kept event", {7'd0, irq_n}, 8'h00);
    rd(8'h03, 8'h00, d);
    peek(8'h03, d); check("R5 status1 empty", d, 8'h00);
  endtask

  task automatic t_status2_enable;
    logic [7:0] d;
    wr(8'h06, 8'h10);
    peek(8'h06, d); check("R2 enable2 readback", d, 8'h10);
    check("R4 irq_n low via status2 RSSI bit", {7'd0, irq_n}, 8'h00);
    rd(8'h04, 8'h00, d); check("R7 status2 pre-clear", d, 8'h3C);
    peek(8'h04, d); check("R6 status2 masked bits kept", d, 8'h2C);
    check("R4 irq_n high", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_bad_writes;
    logic [7:0] d;
    wr(8'h03, 8'hFF);
    wr(8'h04, 8'hFF);
    wr(8'h07, 8'hFF);
    wr(8'h00, 8'hFF);
    peek(8'h03, d); check("R9 status1 unwritable", d, 8'h00);
    peek(8'h04, d); check("R9 status2 unwritable", d, 8'h2C);
    peek(8'h05, d); check("R9 enable1 untouched", d, 8'hFF);
    peek(8'h06, d); check("R9 enable2 untouched", d, 8'h10);
    peek(8'h07, d); check("R2 unmapped reads zero", d, 8'h00);
    check("R9 irq_n unchanged", {7'd0, irq_n}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_por_clear();
    t_masked_latch();
    t_enable_and_clear();
    t_same_cycle();
    t_status2_enable();
    t_bad_writes();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule